// File: doc/BRIEF.md
# Triggered ADC Sample Window Extractor

The block keeps a rolling history of 12-bit ADC samples, writing one sample every clock into a ring memory that is overwritten without pause. A trigger pulse marks a point in time. The block then reaches back a programmable number of samples and takes a window of programmable width, so the window can sit well before the trigger. This lets the trigger decision arrive late.

Each trigger becomes one frame on a valid/ready output stream. The frame is a header word followed by the window reduced in one of three ways: every raw sample, the sum of the samples as a pulse charge, or the time at which the pulse crosses half its height. The time has a six-bit fraction of a sample. Triggers that arrive while an earlier window is still being processed wait in a small queue.

Top module: `swe_window_extractor`

## Requirements
- R1: After reset, `m_valid`, `m_last` and `ovf` are 0.
- R2: On every clock out of reset the block stores `adc_sample`. A trigger seen on the edge that stores sample n selects samples n - `cfg_lookback` up to n - `cfg_lookback` + width - 1, oldest first. `cfg_lookback` is latched with the trigger.
- R3: Up to 4 triggers can wait behind the window in progress. A trigger that arrives while 4 are waiting is dropped and sets `ovf`, which stays 1 until reset.
- R4: Every accepted trigger yields one frame that starts with a header word, never marked last. The header holds bits [23:22]=11, [21:20]=mode code, [19:16]=0 and [15:0]=trigger number. The trigger number counts every trigger pulse since reset, dropped ones included, starting at 0.
- R5: The mode code and `cfg_width` (1 to 512) are latched when a frame starts. Mode code 0 is raw, 1 is sum and 2 is time. Code 3 behaves as raw and is reported as 0.
- R6: Raw mode sends one word per window sample, oldest first: [23:22]=00, [21:12]=0, [11:0]=sample. `m_last` is set on the final word.
- R7: Sum mode sends one word, marked last: [23:22]=01, [21:0]=sum of all window samples.
- R8: Time mode (width at least 5) computes ped = floor(sum of the first 4 samples / 4), peak = the largest window sample, thr = floor((peak - ped)/2) and v[i] = sample[i] - ped. It finds the smallest i in 1..width-1 with v[i-1] <= thr < v[i]. It sends one word, marked last: [23:22]=10, [21]=0, [20:15]=0, [14:6]=i-1, [5:0]=floor(64*(thr - v[i-1])/(v[i] - v[i-1])).
- R9: If time mode finds no such i, the word is [23:22]=10, [21]=1 and all other bits 0.
- R10: While `m_valid` is 1 and `m_ready` is 0, `m_data` and `m_last` hold. No word is lost or repeated.
- R11: Frames leave in the order of their triggers, so header trigger numbers strictly increase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adc_sample | input | 12 | ADC sample, one per clock |
| trig | input | 1 | Trigger pulse, one cycle per trigger |
| cfg_lookback | input | 11 | Distance back from the trigger to the window start |
| cfg_width | input | 10 | Window width in samples, 1 to 512 |
| cfg_mode | input | 2 | Reduction mode code |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts the word |
| m_data | output | 24 | Output word |
| m_last | output | 1 | Final word of a frame |
| ovf | output | 1 | Sticky flag for a dropped trigger |

## Verification
The checks assume that the configuration changes only while no trigger is pending or in progress. They assume that `cfg_lookback` exceeds the width, that the look-back plus the queueing delay stays below the 2048-entry history, and that no trigger comes before the history has been filled once. The bench waits out the first fill and changes the configuration only after the output has been idle long enough to drain. It keeps the look-back at or below 600 and spaces triggers in the random rounds so that queued windows are read before they are overwritten. A directed burst with `m_ready` held low drives the queue to overflow.

// File: rtl/swe_pkg.sv
// Shared constants for the window extractor: output word layout, mode
// codes and controller states. Assumes a 24-bit output word.
package swe_pkg;
    localparam int WORD_W     = 24;
    localparam int TRIG_NUM_W = 16;
    localparam int FRAC_W     = 6;

    localparam logic [1:0] MODE_RAW  = 2'd0;
    localparam logic [1:0] MODE_SUM  = 2'd1;
    localparam logic [1:0] MODE_TIME = 2'd2;

    localparam logic [1:0] TAG_RAW  = 2'b00;
    localparam logic [1:0] TAG_SUM  = 2'b01;
    localparam logic [1:0] TAG_TIME = 2'b10;
    localparam logic [1:0] TAG_HDR  = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_RAW_ISS, S_RAW_LD, S_SCAN, S_PREP, S_DIV, S_EMIT
    } state_e;
endpackage

// File: rtl/swe_ring_ram.sv
// Ring sample memory: one write port and one read port whose data is
// registered, so it appears one cycle after the address.
// Assumes the read address never equals the write address in the same cycle.
// The contents are not reset.
module swe_ring_ram #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 2048,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming sample.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/swe_trig_fifo.sv
// Small FIFO that holds pending triggers (window start address and trigger
// number). Assumes the caller never pushes when full and never pops when empty.
module swe_trig_fifo #(
    parameter int W     = 27,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign dout  = slot[rp];

    // Write the entry into its slot.
    always_ff @(posedge clk) begin
        if (push) slot[wp] <= din;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (!push && pop) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/swe_frac_div.sv
// Serial restoring divider for a proper fraction: returns floor(2^Q_W*num/den)
// after Q_W cycles, with done pulsed for one cycle.
// Assumes num < den and den > 0.
module swe_frac_div #(
    parameter int VAL_W = 14,
    parameter int Q_W   = 6,
    localparam int CNT_W = $clog2(Q_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VAL_W-1:0] num,
    input  logic [VAL_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quot
);
    logic [VAL_W:0]   rem, rem2, dext;
    logic [VAL_W-1:0] dreg;
    logic [CNT_W-1:0] cnt;
    logic             ge;

    // One quotient bit per step: double the remainder and subtract if it fits.
    always_comb begin
        rem2 = {rem[VAL_W-1:0], 1'b0};
        dext = {1'b0, dreg};
        ge   = (rem2 >= dext);
    end

    // Iterate the division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            dreg <= '0;
            quot <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else if (start) begin
            rem  <= {1'b0, num};
            dreg <= den;
            quot <= '0;
            cnt  <= CNT_W'(Q_W);
            done <= 1'b0;
        end else begin
            done <= (cnt == CNT_W'(1));
            if (cnt != '0) begin
                rem  <= ge ? rem2 - dext : rem2;
                quot <= {quot[Q_W-2:0], ge};
                cnt  <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/swe_window_extractor.sv
// Triggered window extractor. Records samples continuously into a ring and
// queues triggers with their window start. Each window is read back and sent
// as a header plus raw samples, a charge sum, or a half-height crossing time.
// Assumes the configuration is steady while triggers are pending, that
// lookback > width, and that windows are read before they are overwritten.
module swe_window_extractor
    import swe_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int MEM_DEPTH  = 2048,
    parameter int MAX_WIN    = 512,
    parameter int FIFO_DEPTH = 4,
    localparam int ADDR_W = $clog2(MEM_DEPTH),
    localparam int IDX_W  = $clog2(MAX_WIN),
    localparam int WIN_W  = IDX_W + 1,
    localparam int SUM_W  = DATA_W + IDX_W,
    localparam int PED_W  = DATA_W + 2,
    localparam int VAL_W  = DATA_W + 2,
    localparam int ENT_W  = TRIG_NUM_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] adc_sample,
    input  logic              trig,
    input  logic [ADDR_W-1:0] cfg_lookback,
    input  logic [WIN_W-1:0]  cfg_width,
    input  logic [1:0]        cfg_mode,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [WORD_W-1:0] m_data,
    output logic              m_last,
    output logic              ovf
);
    // Recording side
    logic [ADDR_W-1:0]     wptr;
    logic [TRIG_NUM_W-1:0] trig_cnt;
    logic                  f_push, f_pop, f_empty, f_full;
    logic [ENT_W-1:0]      f_din, f_dout;

    // Controller state
    state_e                state;
    logic [ADDR_W-1:0]     base;
    logic [TRIG_NUM_W-1:0] num;
    logic [WIN_W-1:0]      wlen, iss_idx;
    logic [1:0]            mode;
    logic                  dv, pass, found;
    logic [IDX_W-1:0]      didx, coarse;
    logic [SUM_W-1:0]      sum;
    logic [PED_W-1:0]      ped_acc;
    logic [DATA_W-1:0]     peak, ped, ped_c;
    logic signed [VAL_W-1:0] thr_s, prev, cur;
    logic [VAL_W-1:0]      dnum, dden;
    logic [WORD_W-1:0]     emit_word;
    logic [ADDR_W-1:0]     rd_addr;
    logic [DATA_W-1:0]     rd_q;
    logic                  scan_go, raw_last, div_start, div_done;
    logic [FRAC_W-1:0]     frac;

    // Output register
    logic                  o_valid, o_last, can_load, ld, ld_last;
    logic [WORD_W-1:0]     o_data, ld_word;

    assign f_push = trig && !f_full;
    assign f_pop  = (state == S_IDLE) && !f_empty;
    assign f_din  = {trig_cnt, wptr - cfg_lookback};

    // Advance the write pointer, number triggers and latch overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            trig_cnt <= '0;
            ovf      <= 1'b0;
        end else begin
            wptr <= wptr + 1'b1;
            if (trig) trig_cnt <= trig_cnt + 1'b1;
            if (trig && f_full) ovf <= 1'b1;
        end
    end

    swe_ring_ram #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_ram (
        .clk(clk), .wr_en(rst_n), .wr_addr(wptr), .wr_data(adc_sample),
        .rd_addr(rd_addr), .rd_data(rd_q)
    );

    swe_trig_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(f_push), .din(f_din), .pop(f_pop),
        .dout(f_dout), .empty(f_empty), .full(f_full)
    );

    swe_frac_div #(.VAL_W(VAL_W), .Q_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(dnum), .den(dden),
        .done(div_done), .quot(frac)
    );

    // Address, scan control and arithmetic helpers.
    always_comb begin
        rd_addr   = base + ADDR_W'(iss_idx);
        scan_go   = (iss_idx < wlen);
        raw_last  = (iss_idx == wlen - 1'b1);
        ped_c     = DATA_W'(ped_acc >> 2);
        cur       = $signed({2'b00, rd_q}) - $signed({2'b00, ped});
        div_start = (state == S_SCAN) && pass && !scan_go && !dv && found;
        can_load  = !o_valid || m_ready;
    end

    // Choose the word that the current state offers to the output register.
    always_comb begin
        ld      = 1'b0;
        ld_last = 1'b0;
        ld_word = '0;
        case (state)
            S_HDR: begin
                ld      = can_load;
                ld_word = {TAG_HDR, mode, 4'b0000, num};
            end
            S_RAW_LD: begin
                ld      = can_load;
                ld_last = raw_last;
                ld_word = {TAG_RAW, (WORD_W - 2 - DATA_W)'(0), rd_q};
            end
            S_EMIT: begin
                ld      = can_load;
                ld_last = 1'b1;
                ld_word = emit_word;
            end
            default: ;
        endcase
    end

    // Frame controller: pop a trigger, read its window, reduce it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            base      <= '0;
            num       <= '0;
            wlen      <= '0;
            mode      <= MODE_RAW;
            iss_idx   <= '0;
            dv        <= 1'b0;
            didx      <= '0;
            pass      <= 1'b0;
            found     <= 1'b0;
            sum       <= '0;
            ped_acc   <= '0;
            peak      <= '0;
            ped       <= '0;
            thr_s     <= '0;
            prev      <= '0;
            coarse    <= '0;
            dnum      <= '0;
            dden      <= '0;
            emit_word <= '0;
        end else begin
            case (state)
                S_IDLE: if (!f_empty) begin
                    base    <= f_dout[ADDR_W-1:0];
                    num     <= f_dout[ADDR_W +: TRIG_NUM_W];
                    wlen    <= cfg_width;
                    mode    <= (cfg_mode == 2'd3) ? MODE_RAW : cfg_mode;
                    iss_idx <= '0;
                    dv      <= 1'b0;
                    pass    <= 1'b0;
                    found   <= 1'b0;
                    sum     <= '0;
                    ped_acc <= '0;
                    peak    <= '0;
                    state   <= S_HDR;
                end
                S_HDR: if (can_load)
                    state <= (mode == MODE_RAW) ? S_RAW_ISS : S_SCAN;
                S_RAW_ISS: state <= S_RAW_LD;
                S_RAW_LD: if (can_load) begin
                    iss_idx <= iss_idx + 1'b1;
                    state   <= raw_last ? S_IDLE : S_RAW_ISS;
                end
                S_SCAN: begin
                    if (scan_go) iss_idx <= iss_idx + 1'b1;
                    dv   <= scan_go;
                    didx <= iss_idx[IDX_W-1:0];
                    if (dv && !pass) begin
                        sum <= sum + SUM_W'(rd_q);
                        if (didx < IDX_W'(4)) ped_acc <= ped_acc + PED_W'(rd_q);
                        if (rd_q > peak) peak <= rd_q;
                    end
                    if (dv && pass) begin
                        if (didx != '0 && !found && prev <= thr_s && cur > thr_s) begin
                            found  <= 1'b1;
                            coarse <= didx - 1'b1;
                            dnum   <= VAL_W'(thr_s - prev);
                            dden   <= VAL_W'(cur - prev);
                        end
                        prev <= cur;
                    end
                    if (!scan_go && !dv) begin
                        if (!pass) begin
                            if (mode == MODE_SUM) begin
                                emit_word <= {TAG_SUM, (WORD_W - 2 - SUM_W)'(0), sum};
                                state     <= S_EMIT;
                            end else begin
                                state <= S_PREP;
                            end
                        end else if (found) begin
                            state <= S_DIV;
                        end else begin
                            emit_word <= {TAG_TIME, 1'b1, (WORD_W - 3)'(0)};
                            state     <= S_EMIT;
                        end
                    end
                end
                S_PREP: begin
                    ped     <= ped_c;
                    thr_s   <= $signed(VAL_W'((peak - ped_c) >> 1));
                    iss_idx <= '0;
                    dv      <= 1'b0;
                    pass    <= 1'b1;
                    found   <= 1'b0;
                    prev    <= '0;
                    state   <= S_SCAN;
                end
                S_DIV: if (div_done) begin
                    emit_word <= {TAG_TIME, 1'b0,
                                  (WORD_W - 3 - IDX_W - FRAC_W)'(0), coarse, frac};
                    state     <= S_EMIT;
                end
                S_EMIT: if (can_load) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output register with valid/ready hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_last  <= 1'b0;
            o_data  <= '0;
        end else if (ld) begin
            o_valid <= 1'b1;
            o_last  <= ld_last;
            o_data  <= ld_word;
        end else if (m_ready) begin
            o_valid <= 1'b0;
            o_last  <= 1'b0;
        end
    end

    assign m_valid = o_valid;
    assign m_data  = o_data;
    assign m_last  = o_last;
endmodule

// File: rtl/swe_window_extractor_chk.sv
// Protocol checker for the window extractor output stream and overflow flag.
module swe_window_extractor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        m_valid,
    input logic        m_ready,
    input logic [23:0] m_data,
    input logic        m_last,
    input logic        ovf
);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid);

    p_header_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_data[23:22] == 2'b11 |-> !m_last && m_data[19:16] == 4'h0);

    p_invalid_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_data[23:21] == 3'b101 |-> m_data[20:0] == 21'd0 && m_last);

    p_time_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_data[23:21] == 3'b100 |-> m_data[20:15] == 6'd0 && m_last);
endmodule

bind swe_window_extractor swe_window_extractor_chk u_chk (.*);

// File: tb/swe_window_extractor_test.sv
// Bench: random samples with injected pulses, random trigger spacing and
// ready pattern, plus directed corner cases, against a bench-side model.
module swe_window_extractor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] adc_sample = '0;
    logic        trig = 1'b0;
    logic [10:0] cfg_lookback = 11'd100;
    logic [9:0]  cfg_width = 10'd8;
    logic [1:0]  cfg_mode = 2'd0;
    logic        m_valid, m_ready = 1'b1, m_last, ovf;
    logic [23:0] m_data;

    swe_window_extractor uut (
        .clk(clk), .rst_n(rst_n), .adc_sample(adc_sample), .trig(trig),
        .cfg_lookback(cfg_lookback), .cfg_width(cfg_width), .cfg_mode(cfg_mode),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .ovf(ovf)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    int hist [65536];
    int tstart [1024];
    bit rxd [1024];
    int wcnt = 0, tnum = 0, cyc = 0, frames = 0, last_num = -1;
    int rdy_mode = 1, gen_mode = 0, force_val = 0;
    int pulse_t = -1, pulse_amp = 0;
    bit in_frame = 0, finished = 0;
    int expq [$];
    string cur_tag = "";

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int h(int i);
        return hist[i & 65535];
    endfunction

    // Expected time word per R8 and R9.
    function automatic int time_word(int st, int w);
        int ped, peak, thr, a, b;
        ped = (h(st) + h(st + 1) + h(st + 2) + h(st + 3)) / 4;
        peak = 0;
        for (int k = 0; k < w; k++) if (h(st + k) > peak) peak = h(st + k);
        thr = (peak - ped) / 2;
        for (int i = 1; i < w; i++) begin
            a = h(st + i - 1) - ped;
            b = h(st + i) - ped;
            if (a <= thr && b > thr)
                return (2 << 22) | ((i - 1) << 6) | (((thr - a) * 64) / (b - a));
        end
        return (2 << 22) | (1 << 21);
    endfunction

    task automatic build(int n);
        int st, w, md, s;
        st = tstart[n & 1023];
        w = int'(cfg_width);
        md = (cfg_mode == 2'd3) ? 0 : int'(cfg_mode);
        if (md == 0) begin
            cur_tag = "R2 R6 raw word";
            for (int k = 0; k < w; k++) expq.push_back(h(st + k));
        end else if (md == 1) begin
            cur_tag = "R2 R7 sum word";
            s = 0;
            for (int k = 0; k < w; k++) s += h(st + k);
            expq.push_back((1 << 22) | s);
        end else begin
            cur_tag = "R8 R9 time word";
            expq.push_back(time_word(st, w));
        end
    endtask

    task automatic on_word(logic [23:0] d, logic l);
        int n, e, md;
        if (!in_frame) begin
            n = int'(d[15:0]);
            md = (cfg_mode == 2'd3) ? 0 : int'(cfg_mode);
            chk(d[23:22] == 2'b11, "R4 header tag", int'(d[23:22]), 3);
            chk(int'(d[21:20]) == md, "R5 header mode", int'(d[21:20]), md);
            chk(n > last_num, "R11 trigger order", n, last_num + 1);
            chk(l == 1'b0, "R4 header not last", int'(l), 0);
            last_num = n;
            rxd[n & 1023] = 1'b1;
            build(n);
            in_frame = 1'b1;
        end else begin
            e = (expq.size() > 0) ? expq.pop_front() : -1;
            chk(int'(d) == e, cur_tag, int'(d), e);
            chk(l == (expq.size() == 0), "R10 last flag", int'(l), int'(expq.size() == 0));
            if (expq.size() == 0) begin
                in_frame = 1'b0;
                frames++;
            end
        end
    endtask

    // Record history and triggers exactly as the block sees them; watchdog.
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            hist[wcnt & 65535] = int'(adc_sample);
            if (trig) begin
                tstart[tnum & 1023] = wcnt - int'(cfg_lookback);
                tnum++;
            end
            wcnt++;
        end
        if (cyc > 190000 && !finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Drive samples and ready, then observe the coming transfer.
    always @(negedge clk) begin
        int v;
        if (rdy_mode == 0) m_ready = 1'b0;
        else if (rdy_mode == 1) m_ready = 1'b1;
        else m_ready = ($urandom_range(0, 9) < 7);
        if (gen_mode == 1) begin
            v = force_val;
        end else begin
            v = 300 + int'($urandom_range(0, 15));
            if (pulse_t < 0 && $urandom_range(0, 59) == 0) begin
                pulse_t = 0;
                pulse_amp = int'($urandom_range(200, 3000));
            end
            if (pulse_t >= 0) begin
                if (pulse_t < 4) v += pulse_amp * (pulse_t + 1) / 4;
                else v += pulse_amp * (16 - pulse_t) / 12;
                pulse_t = (pulse_t >= 15) ? -1 : pulse_t + 1;
            end
            if (v > 4095) v = 4095;
        end
        adc_sample = 12'(v);
        #1;
        if (rst_n && m_valid && m_ready) on_word(m_data, m_last);
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic drain();
        int idle = 0;
        while (idle < 1300) begin
            @(negedge clk);
            idle = m_valid ? 0 : idle + 1;
        end
    endtask

    initial begin
        int f0, t0, base;
        void'($urandom(32'd20240611));
        cycles(5);
        rst_n = 1'b1;
        #1;
        chk(m_valid == 1'b0, "R1 reset valid", int'(m_valid), 0);
        chk(m_last == 1'b0, "R1 reset last", int'(m_last), 0);
        chk(ovf == 1'b0, "R1 reset overflow", int'(ovf), 0);
        cycles(2100);

        // Random rounds in each mode, triggers spaced to avoid drops.
        for (int round = 0; round < 9; round++) begin
            cfg_mode = 2'(round % 3);
            cfg_width = 10'((round % 3 == 2) ? $urandom_range(5, 64) : $urandom_range(1, 64));
            cfg_lookback = 11'($urandom_range(100, 600));
            rdy_mode = (round % 2 == 0) ? 2 : 1;
            f0 = frames;
            t0 = tnum;
            for (int k = 0; k < 6; k++) begin
                fire();
                cycles(int'($urandom_range(250, 400)));
            end
            drain();
            chk(frames - f0 == tnum - t0, "R10 no frame lost", frames - f0, tnum - t0);
        end

        // Width 1 in raw and sum modes.
        rdy_mode = 2;
        cfg_lookback = 11'd40;
        cfg_width = 10'd1;
        cfg_mode = 2'd0;
        fire();
        drain();
        cfg_mode = 2'd1;
        fire();
        drain();

        // Mode code 3 behaves as raw.
        cfg_mode = 2'd3;
        cfg_width = 10'd3;
        fire();
        drain();

        // Widest window of full-scale samples: largest sum.
        gen_mode = 1;
        force_val = 4095;
        cycles(700);
        cfg_mode = 2'd1;
        cfg_width = 10'd512;
        cfg_lookback = 11'd600;
        f0 = frames;
        fire();
        drain();
        chk(frames - f0 == 1, "R7 full-scale sum frame", frames - f0, 1);

        // Flat signal never crosses: time invalid.
        force_val = 1000;
        cycles(300);
        cfg_mode = 2'd2;
        cfg_width = 10'd32;
        cfg_lookback = 11'd100;
        fire();
        drain();

        // Directed clean ramp pulse for the time mode.
        for (int k = 0; k < 40; k++) begin
            force_val = (k < 10) ? 100 : (k < 20) ? 100 + (k - 9) * 150 : 1600 - (k - 19) * 60;
            @(negedge clk);
        end
        force_val = 100;
        cycles(55);
        cfg_width = 10'd40;
        cfg_lookback = 11'd100;
        fire();
        drain();
        gen_mode = 0;

        // Overflow burst: ready low, seven back-to-back triggers.
        rdy_mode = 0;
        cfg_mode = 2'd1;
        cfg_width = 10'd4;
        cfg_lookback = 11'd50;
        base = tnum;
        @(negedge clk);
        trig = 1'b1;
        cycles(7);
        trig = 1'b0;
        cycles(20);
        chk(ovf == 1'b1, "R3 overflow set", int'(ovf), 1);
        rdy_mode = 1;
        drain();
        for (int k = 0; k < 7; k++)
            chk(rxd[(base + k) & 1023] == (k < 5), "R3 queued or dropped",
                int'(rxd[(base + k) & 1023]), int'(k < 5));
        cycles(50);
        chk(ovf == 1'b1, "R3 overflow sticky", int'(ovf), 1);
        chk(in_frame == 1'b0, "R10 no open frame", int'(in_frame), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule